// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block sits next to an SDRAM controller's command path and follows the life of every bank. It sees each decoded command the controller issues: mode load, activate, read, write or precharge, along with the bank select and the address bus. It keeps a per-bank open flag and the row that was opened there. It also decides in the same cycle whether the command obeys the access rules. The decision appears one clock later as an accept pulse or as an error pulse carrying a reason code.

Two programmable delays are enforced. The first is a settling window after a mode load, during which nothing may be issued. The second is a recovery window per bank after that bank closes, during which it may not be re-activated.

Reads and writes can ask for automatic closing through address bit 10. Precharge can close a single bank or every bank. The column address is extracted from the address bus according to the device data width chosen by a parameter.

Top module: `sdram_bank_tracker`

## Requirements
- R1: A mode load (op 1) is accepted only when no bank is open and address bit 12 is low. With any bank open it is rejected with code 3. With every bank idle but bit 12 high it is rejected with code 5.
- R2: After a mode load is accepted at clock edge E, any command other than no-op (op 0) sampled at edges E+1 through E+T_MRD-1 is rejected with code 4. This check takes priority over every other check.
- R3: An activate (op 2) to an idle bank opens that bank and stores address bits 11:0 as its row. An activate to a bank that is already open is rejected with code 1 and leaves that bank's state unchanged.
- R4: A read (op 3) or write (op 4) is accepted only when the selected bank is open and has no automatic close pending. Otherwise it is rejected with code 2.
- R5: On an accepted read or write, the column output takes the column address. For DQ_WIDTH 4 it is {addr[11], addr[9:0]}. For DQ_WIDTH 8 it is addr[9:0]. For DQ_WIDTH 16 it is addr[8:0]. The value is zero-extended to 11 bits and held until the next accepted read or write.
- R6: A read or write accepted at edge E with address bit 10 set closes its bank at edge E+BURST_LEN. With bit 10 clear, the bank stays open.
- R7: A precharge (op 5) is always accepted outside the mode-load window. With address bit 10 set it closes every bank and the bank select is ignored. With bit 10 clear it closes only the selected bank. Precharging an idle bank changes nothing. An explicit close also cancels a pending automatic close.
- R8: A bank that closes at edge E may be activated at edge E+T_RP or later. An activate at an earlier edge is rejected with code 4.
- R9: For every command with op 1 to 5, exactly one of cmd_accept and err_pulse pulses high for one cycle, visible after the edge that sampled the command. The code is 0 whenever no error pulses. Op values 0, 6 and 7 produce neither pulse and change no state.
- R10: Synchronous reset clears every open flag, every stored row, both pulses, the code, the column output and both delay windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | Command: 0 no-op, 1 mode load, 2 activate, 3 read, 4 write, 5 precharge |
| cmd_bank | input | 2 | Bank select |
| cmd_addr | input | 13 | Address bus (row, column, bit 10 close flag, bit 12 mode check) |
| bank_open | output | 4 | Per-bank open flag, bit i for bank i |
| open_rows | output | 48 | Stored row per bank, bank i in bits 12*i+11 : 12*i |
| cmd_accept | output | 1 | One-cycle pulse: previous command accepted |
| err_pulse | output | 1 | One-cycle pulse: previous command rejected |
| err_code | output | 3 | Reason: 1 bank busy, 2 bank not open, 3 banks not idle, 4 timing, 5 mode bit 12 high |
| acc_col | output | 11 | Column of the last accepted read or write |

## Verification
Every result is registered once. The accept and error pulses, the code, the column and the open flags for activate and precharge all change at the edge that samples the command. They are therefore compared one small delay after that same edge.

An automatic close lands BURST_LEN edges after its read or write. Recovery and mode-load windows are measured in edges from the closing or loading edge.

The bench's model works on an edge counter, recording at which edge each bank closed, each mode load landed and each automatic close falls due. Every output is compared after every edge, so an event that is one cycle early or late is caught on the edge it happens.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_MODE = 3'd1,
    OP_ACT  = 3'd2,
    OP_RD   = 3'd3,
    OP_WR   = 3'd4,
    OP_PRE  = 3'd5
  } trk_op_e;

  typedef enum logic [2:0] {
    RSN_NONE      = 3'd0,
    RSN_BUSY      = 3'd1,
    RSN_NOT_OPEN  = 3'd2,
    RSN_NOT_IDLE  = 3'd3,
    RSN_TIMING    = 3'd4,
    RSN_MODE_ADDR = 3'd5
  } trk_rsn_e;

endpackage

// File: rtl/trk_mrd_timer.sv
module trk_mrd_timer #(
  parameter int T_MRD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);
  localparam int CW = (T_MRD < 2) ? 1 : $clog2(T_MRD + 1);

  logic [CW-1:0] cnt_q;

  // loaded with T_MRD-1 so the first free edge is T_MRD after the load
  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (load)           cnt_q <= CW'(T_MRD - 1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/trk_bank_slot.sv
module trk_bank_slot #(
  parameter int ROW_W     = 12,
  parameter int T_RP      = 3,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_go,
  input  logic             close_go,
  input  logic             ap_go,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] row_q,
  output logic             rp_ok,
  output logic             ap_pend
);
  localparam int RPW = (T_RP < 2) ? 1 : $clog2(T_RP + 1);
  localparam int APW = $clog2(BURST_LEN + 1);

  logic           open_q;
  logic [RPW-1:0] rp_q;
  logic [APW-1:0] ap_q;
  logic           ap_fin;
  logic           shut;

  assign ap_fin = (ap_q == APW'(1));
  assign shut   = open_q && (close_go || ap_fin);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      row_q  <= '0;
      rp_q   <= '0;
      ap_q   <= '0;
    end else begin
      if (shut)        open_q <= 1'b0;
      else if (act_go) open_q <= 1'b1;

      if (act_go) row_q <= row_in;

      if (shut)              ap_q <= '0;
      else if (ap_go)        ap_q <= APW'(BURST_LEN);
      else if (ap_q != '0)   ap_q <= ap_q - 1'b1;

      if (shut)              rp_q <= RPW'(T_RP - 1);
      else if (rp_q != '0)   rp_q <= rp_q - 1'b1;
    end
  end

  assign is_open = open_q;
  assign rp_ok   = (rp_q == '0);
  assign ap_pend = (ap_q != '0);

  assert_act_idle_R3: assert property (@(posedge clk) disable iff (rst)
    act_go |-> !open_q);
  assert_act_recovered_R8: assert property (@(posedge clk) disable iff (rst)
    act_go |-> (rp_q == '0));
  assert_ap_on_open_R6: assert property (@(posedge clk) disable iff (rst)
    ap_go |-> (open_q && ap_q == '0));
  assert_ap_closes_R6: assert property (@(posedge clk) disable iff (rst)
    (open_q && ap_fin) |=> !open_q);

endmodule

// File: rtl/trk_cmd_check.sv
module trk_cmd_check
  import sdram_trk_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic [2:0]             op,
  input  logic [BANK_W-1:0]      bank,
  input  logic                   close_flag,
  input  logic                   mode_bit,
  input  logic [(1<<BANK_W)-1:0] open_vec,
  input  logic [(1<<BANK_W)-1:0] rp_ok_vec,
  input  logic [(1<<BANK_W)-1:0] ap_pend_vec,
  input  logic                   mrd_busy,
  output logic                   accept,
  output logic                   reject,
  output logic [2:0]             code,
  output logic [(1<<BANK_W)-1:0] act_go,
  output logic [(1<<BANK_W)-1:0] close_go,
  output logic [(1<<BANK_W)-1:0] ap_go,
  output logic                   mode_go
);
  localparam int NB = 1 << BANK_W;

  logic known;
  logic is_rw;

  assign known = (op == OP_MODE) || (op == OP_ACT) || (op == OP_RD) ||
                 (op == OP_WR)   || (op == OP_PRE);
  assign is_rw = (op == OP_RD) || (op == OP_WR);

  always_comb begin
    accept = 1'b0;
    code   = RSN_NONE;
    if (known) begin
      if (mrd_busy) begin
        code = RSN_TIMING;
      end else begin
        case (op)
          OP_MODE: begin
            if (|open_vec)      code = RSN_NOT_IDLE;
            else if (mode_bit)  code = RSN_MODE_ADDR;
            else                accept = 1'b1;
          end
          OP_ACT: begin
            if (open_vec[bank])        code = RSN_BUSY;
            else if (!rp_ok_vec[bank]) code = RSN_TIMING;
            else                       accept = 1'b1;
          end
          OP_RD, OP_WR: begin
            if (!open_vec[bank] || ap_pend_vec[bank]) code = RSN_NOT_OPEN;
            else                                      accept = 1'b1;
          end
          default: accept = 1'b1;
        endcase
      end
    end
  end

  assign reject  = known && !accept;
  assign mode_go = accept && (op == OP_MODE);

  for (genvar i = 0; i < NB; i++) begin : g_bank
    logic hit;
    assign hit         = (bank == BANK_W'(i));
    assign act_go[i]   = accept && (op == OP_ACT) && hit;
    assign close_go[i] = accept && (op == OP_PRE) && (close_flag || hit);
    assign ap_go[i]    = accept && is_rw && close_flag && hit;
  end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_trk_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int ADDR_W    = 13,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 11,
  parameter int DQ_WIDTH  = 16,
  parameter int T_MRD     = 2,
  parameter int T_RP      = 3,
  parameter int BURST_LEN = 4,
  parameter int AP_BIT    = 10
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [2:0]                     cmd_op,
  input  logic [BANK_W-1:0]              cmd_bank,
  input  logic [ADDR_W-1:0]              cmd_addr,
  output logic [(1<<BANK_W)-1:0]         bank_open,
  output logic [(1<<BANK_W)*ROW_W-1:0]   open_rows,
  output logic                           cmd_accept,
  output logic                           err_pulse,
  output logic [2:0]                     err_code,
  output logic [COL_W-1:0]               acc_col
);
  localparam int NB       = 1 << BANK_W;
  localparam int MODE_BIT = ADDR_W - 1;

  logic [NB-1:0]    open_vec, rp_ok_vec, ap_pend_vec;
  logic [NB-1:0]    act_go, close_go, ap_go;
  logic             mode_go, mrd_busy;
  logic             acc_c, rej_c;
  logic [2:0]       code_c;
  logic [COL_W-1:0] col_c;

  trk_cmd_check #(.BANK_W(BANK_W)) u_check (
    .op          (cmd_op),
    .bank        (cmd_bank),
    .close_flag  (cmd_addr[AP_BIT]),
    .mode_bit    (cmd_addr[MODE_BIT]),
    .open_vec    (open_vec),
    .rp_ok_vec   (rp_ok_vec),
    .ap_pend_vec (ap_pend_vec),
    .mrd_busy    (mrd_busy),
    .accept      (acc_c),
    .reject      (rej_c),
    .code        (code_c),
    .act_go      (act_go),
    .close_go    (close_go),
    .ap_go       (ap_go),
    .mode_go     (mode_go)
  );

  trk_mrd_timer #(.T_MRD(T_MRD)) u_mrd (
    .clk  (clk),
    .rst  (rst),
    .load (mode_go),
    .busy (mrd_busy)
  );

  for (genvar i = 0; i < NB; i++) begin : g_slot
    trk_bank_slot #(
      .ROW_W(ROW_W), .T_RP(T_RP), .BURST_LEN(BURST_LEN)
    ) u_slot (
      .clk      (clk),
      .rst      (rst),
      .act_go   (act_go[i]),
      .close_go (close_go[i]),
      .ap_go    (ap_go[i]),
      .row_in   (cmd_addr[ROW_W-1:0]),
      .is_open  (open_vec[i]),
      .row_q    (open_rows[i*ROW_W +: ROW_W]),
      .rp_ok    (rp_ok_vec[i]),
      .ap_pend  (ap_pend_vec[i])
    );
  end

  // column field depends on the device data width
  if (DQ_WIDTH == 4) begin : g_col_x4
    assign col_c = COL_W'({cmd_addr[11], cmd_addr[9:0]});
  end else if (DQ_WIDTH == 8) begin : g_col_x8
    assign col_c = COL_W'(cmd_addr[9:0]);
  end else begin : g_col_x16
    assign col_c = COL_W'(cmd_addr[8:0]);
  end

  assign bank_open = open_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_accept <= 1'b0;
      err_pulse  <= 1'b0;
      err_code   <= RSN_NONE;
      acc_col    <= '0;
    end else begin
      cmd_accept <= acc_c;
      err_pulse  <= rej_c;
      err_code   <= code_c;
      if (acc_c && (cmd_op == OP_RD || cmd_op == OP_WR)) acc_col <= col_c;
    end
  end

  assert_mode_needs_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_MODE && |bank_open && !mrd_busy) |=> (err_pulse && err_code == RSN_NOT_IDLE));
  assert_mrd_window_R2: assert property (@(posedge clk) disable iff (rst)
    (mrd_busy && cmd_op != OP_NOP) |=> (!cmd_accept));
  assert_pulse_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(cmd_accept && err_pulse));
  assert_code_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !err_pulse |-> (err_code == RSN_NONE));
  assert_pre_all_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_PRE && cmd_addr[AP_BIT] && !mrd_busy) |=> (bank_open == '0));

endmodule

// File: tb/sim_sdram_bank_tracker.sv
`timescale 1ns/1ps
module sim_sdram_bank_tracker;
  localparam int NB = 4, TMRD = 2, TRP = 3, BL = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  op;
  logic [1:0]  bk;
  logic [12:0] ad;
  logic [3:0]  bank_open;
  logic [47:0] open_rows;
  logic        cmd_accept, err_pulse;
  logic [2:0]  err_code;
  logic [10:0] acc_col;

  sdram_bank_tracker #(
    .DQ_WIDTH(4), .T_MRD(TMRD), .T_RP(TRP), .BURST_LEN(BL)
  ) u0 (
    .clk(clk), .rst(rst), .cmd_op(op), .cmd_bank(bk), .cmd_addr(ad),
    .bank_open(bank_open), .open_rows(open_rows), .cmd_accept(cmd_accept),
    .err_pulse(err_pulse), .err_code(err_code), .acc_col(acc_col)
  );

  always #2 clk = ~clk;

  int vectors = 0, fails = 0, n = 0;
  int m_open[NB], m_row[NB], m_closed[NB], m_apend[NB], m_mode;
  int e_acc, e_err, e_code, e_col;

  task automatic chk(input string tag, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at edge %0d: actual=%0h expected=%0h", tag, n, act, exp);
    end
  endtask

  task automatic model(input int o, input int b, input logic [12:0] a);
    int acc, code, any;
    acc = 0; code = 0; any = 0;
    for (int i = 0; i < NB; i++) any |= m_open[i];
    if (o >= 1 && o <= 5) begin
      if (n - m_mode < TMRD) code = 4;
      else if (o == 1) begin
        if (any != 0) code = 3; else if (a[12]) code = 5; else acc = 1;
      end else if (o == 2) begin
        if (m_open[b] != 0) code = 1;
        else if (n - m_closed[b] < TRP) code = 4;
        else acc = 1;
      end else if (o == 3 || o == 4) begin
        if (m_open[b] == 0 || m_apend[b] >= n) code = 2; else acc = 1;
      end else acc = 1;
    end
    e_acc = acc; e_code = code;
    e_err = (o >= 1 && o <= 5 && acc == 0) ? 1 : 0;
    if (acc != 0 && (o == 3 || o == 4)) e_col = (int'(a[11]) << 10) | int'(a[9:0]);
    for (int i = 0; i < NB; i++) begin
      if (m_open[i] != 0 && acc != 0 && o == 5 && (a[10] || b == i)) begin
        m_open[i] = 0; m_closed[i] = n; m_apend[i] = -1;
      end else if (m_open[i] != 0 && m_apend[i] == n) begin
        m_open[i] = 0; m_closed[i] = n; m_apend[i] = -1;
      end
    end
    if (acc != 0 && o == 2) begin m_open[b] = 1; m_row[b] = int'(a[11:0]); end
    if (acc != 0 && (o == 3 || o == 4) && a[10]) m_apend[b] = n + BL;
    if (acc != 0 && o == 1) m_mode = n;
  endtask

  task automatic compare_all();
    logic [3:0]  xo;
    logic [47:0] xr;
    for (int i = 0; i < NB; i++) begin
      xo[i] = m_open[i][0];
      xr[i*12 +: 12] = m_row[i][11:0];
    end
    chk("R3/R6/R7 bank_open", bank_open, xo);
    chk("R3 open_rows", open_rows, xr);
    chk("R9 cmd_accept", cmd_accept, e_acc);
    chk("R9 err_pulse", err_pulse, e_err);
    chk("R1/R2/R4/R8 err_code", err_code, e_code);
    chk("R5 acc_col", acc_col, e_col);
  endtask

  task automatic step(input int o, input int b, input int a);
    @(negedge clk);
    op = 3'(o); bk = 2'(b); ad = 13'(a);
    model(o, b, 13'(a));
    @(posedge clk);
    #1;
    compare_all();
    n++;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; op = '0; bk = '0; ad = '0;
    for (int i = 0; i < NB; i++) begin
      m_open[i] = 0; m_row[i] = 0; m_closed[i] = -100; m_apend[i] = -1;
    end
    m_mode = -100; e_acc = 0; e_err = 0; e_code = 0; e_col = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare_all();                  // R10 reset state
    step(1, 0, 13'h0000);           // R1 mode load accepted
    step(2, 0, 13'h0005);           // R2 blocked in window
    step(1, 0, 13'h1000);           // R1 bit 12 high -> code 5
    step(2, 0, 13'h0abc);           // R3 open bank 0
    step(2, 0, 13'h0123);           // R3 busy
    step(3, 1, 13'h0000);           // R4 idle bank
    step(3, 0, 13'h0a55);           // R5 column with bit 11
    step(1, 0, 13'h0000);           // R1 banks not idle
    step(4, 0, 13'h0407);           // R6 write with close
    step(3, 0, 13'h0001);           // R4 close pending
    step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
    step(2, 0, 13'h0111);           // R8 too early
    step(0, 0, 0);
    step(2, 0, 13'h0111);           // R8 just recovered
    step(2, 1, 13'h0222);
    step(2, 2, 13'h0333);
    step(3, 1, 13'h0012);           // R6 bit 10 clear keeps row
    step(5, 1, 13'h0000);           // R7 single bank
    step(5, 1, 13'h0000);           // R7 idle bank precharge
    step(6, 2, 13'h0fff);           // R9 unused op ignored
    step(5, 3, 13'h0400);           // R7 all banks, select ignored
    step(2, 0, 13'h0001);           // R8 timing after all-close
    for (int k = 0; k < 600; k++) step(int'($urandom % 7), int'($urandom % 4), int'($urandom));
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule